// File: doc/BRIEF.md
# Multi-Channel Pulse Control Hub

The hub sits between one simple memory-mapped register bus and a row of pulse generator channels, up to sixteen of them. Each bus access lands in one of two places. It either goes to a small shared register set held inside the hub, or it is forwarded to the register window of exactly one channel. The hub forwards the word index, the write enable and the write data to that channel. It picks that channel's read data for the response.

The shared set holds one clock-enable bit per channel. Each bit drives that channel's clock-gate enable directly, so an idle channel can be switched off. The shared set also turns writes into one-cycle start and stop strobes for any subset of channels. A combined register carries start bits and stop bits in one word, so one write can start some channels and halt others in the same cycle.

Every access takes one cycle to answer. Addresses that map to nothing are answered with an error flag and zero data.

Top module: `chan_ctrl_hub`

## Requirements
- R1: The region field `busAddr[ADDR_W-1:8]` selects the target. Region 0 is the shared set, and region k+1 is channel k for k below N_CH. For a channel access, `chReq` is one-hot at bit k in the request cycle. In that cycle `chAddr` = `busAddr[7:2]`, and `chWe` and `chWdata` follow the bus.
- R2: `busReady` is high exactly in the cycle after each cycle with `busReq` high, and low otherwise.
- R3: A channel read returns slice k of `chRdata` (bits `[32k+31:32k]`), as sampled in the request cycle. Every write returns zero data.
- R4: The clock-enable register is word 0 of the shared set. A write loads its bits [N_CH-1:0], a read returns them zero-extended, and `clkGateEn` shows its current value.
- R5: Writing word 1 (start mask) or word 2 (stop mask) raises `startStb` or `stopStb` for the masked channels for exactly the response cycle. Reads of these words return zero.
- R6: A start strobe reaches only those channels whose clock-enable bit is set when the write is accepted.
- R7: Word 3 carries start bits in [15:0] and stop bits in [31:16], and both act in the same cycle. When a channel is both started and stopped, it gets only the stop strobe.
- R8: An access to shared word 4 or above, or to a region above N_CH, sets `busErr` in the response cycle and returns zero data. Such a write changes no state and raises no strobe. Address bits [1:0] are ignored.
- R9: After reset, `busReady`, `busErr`, `busRdata`, `clkGateEn`, `startStb` and `stopStb` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busReq | input | 1 | Access request |
| busWe | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, valid with busReady |
| busReady | output | 1 | Response valid |
| busErr | output | 1 | Access hit an unmapped address |
| chReq | output | N_CH | Per-channel request, one-hot |
| chWe | output | 1 | Write enable forwarded to channels |
| chAddr | output | 6 | Word index inside the channel window |
| chWdata | output | DATA_W | Write data forwarded to channels |
| chRdata | input | N_CH*DATA_W | Concatenated channel read data |
| clkGateEn | output | N_CH | Per-channel clock-gate enable |
| startStb | output | N_CH | Per-channel one-cycle start strobe |
| stopStb | output | N_CH | Per-channel one-cycle stop strobe |

## Verification
Two things can fall in the same cycle: a start and a stop aimed at the same channel, and a start aimed at a channel whose clock is gated. The bench provokes the first with combined-register writes that set both the start bit and the stop bit for chosen channels. A correct response shows only the stop strobe on those channels, while the channels that were only started see their start strobe. The bench provokes the second by writing start masks while some or all clock enables are clear. Each response-cycle strobe vector is compared with the mask ANDed with the enable value written earlier.

// File: rtl/hub_pkg.sv
package hub_pkg;

  // word index of each register in the shared block
  typedef enum logic [5:0] {
    GR_CLKEN  = 6'd0,
    GR_START  = 6'd1,
    GR_STOP   = 6'd2,
    GR_GOHALT = 6'd3
  } genReg_e;

  // decoded command handed from control to datapath
  typedef struct packed {
    logic wrClkEn;
    logic rdClkEn;
    logic wrStart;
    logic wrStop;
    logic wrGoHalt;
    logic rdCh;
    logic chSel;
    logic err;
  } hubCmd_t;

  localparam int WIN_SHIFT = 8;   // 64 words of 4 bytes per window
  localparam int HALF_W    = 16;  // stop bits start here in the combined word

endpackage

// File: rtl/hub_ctrl.sv
module hub_ctrl
  import hub_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int ADDR_W = 13,
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              busReq,
  input  logic              busWe,
  input  logic [ADDR_W-1:2] busAddrW,
  output hubCmd_t           cmd,
  output logic [N_CH-1:0]   chOneHot,
  output logic [IDX_W-1:0]  chIdx
);

  localparam int REG_W = ADDR_W - WIN_SHIFT;

  logic [REG_W-1:0] region;
  logic [5:0]       word;
  logic             inGen;
  logic             inCh;

  assign region = busAddrW[ADDR_W-1:WIN_SHIFT];
  assign word   = busAddrW[WIN_SHIFT-1:2];
  assign inGen  = (region == '0);
  assign inCh   = !inGen && (region <= REG_W'(N_CH));

  // one select line per channel window
  for (genvar k = 0; k < N_CH; k++) begin : g_sel
    assign chOneHot[k] = busReq && (region == REG_W'(k + 1));
  end

  always_comb begin
    chIdx = '0;
    for (int k = 0; k < N_CH; k++) begin
      if (chOneHot[k]) chIdx = IDX_W'(k);
    end
  end

  always_comb begin
    cmd = '0;
    if (busReq) begin
      if (inGen) begin
        case (word)
          GR_CLKEN: begin
            cmd.wrClkEn = busWe;
            cmd.rdClkEn = !busWe;
          end
          GR_START:  cmd.wrStart  = busWe;
          GR_STOP:   cmd.wrStop   = busWe;
          GR_GOHALT: cmd.wrGoHalt = busWe;
          default:   cmd.err      = 1'b1;
        endcase
      end else if (inCh) begin
        cmd.chSel = 1'b1;
        cmd.rdCh  = !busWe;
      end else begin
        cmd.err = 1'b1;
      end
    end
  end

endmodule

// File: rtl/hub_dp.sv
module hub_dp
  import hub_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busReq,
  input  logic [DATA_W-1:0]      busWdata,
  input  hubCmd_t                cmd,
  input  logic [IDX_W-1:0]       chIdx,
  input  logic [N_CH*DATA_W-1:0] chRdata,
  output logic [N_CH-1:0]        clkEn,
  output logic [N_CH-1:0]        startStb,
  output logic [N_CH-1:0]        stopStb,
  output logic [DATA_W-1:0]      busRdata,
  output logic                   busReady,
  output logic                   busErr
);

  logic [N_CH-1:0]   startMask;
  logic [N_CH-1:0]   stopMask;
  logic [DATA_W-1:0] rdNext;

  assign startMask = ({N_CH{cmd.wrStart | cmd.wrGoHalt}} & busWdata[N_CH-1:0]);
  assign stopMask  = ({N_CH{cmd.wrStop}}  & busWdata[N_CH-1:0])
                   | ({N_CH{cmd.wrGoHalt}} & busWdata[HALF_W +: N_CH]);

  // per-channel enable and strobe flops
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        clkEn[k]    <= 1'b0;
        startStb[k] <= 1'b0;
        stopStb[k]  <= 1'b0;
      end else begin
        if (cmd.wrClkEn) clkEn[k] <= busWdata[k];
        stopStb[k]  <= stopMask[k];
        startStb[k] <= startMask[k] && clkEn[k] && !stopMask[k];
      end
    end
  end

  always_comb begin
    rdNext = '0;
    if (cmd.rdClkEn) rdNext = DATA_W'(clkEn);
    else if (cmd.rdCh) rdNext = chRdata[chIdx*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busReady <= 1'b0;
      busErr   <= 1'b0;
      busRdata <= '0;
    end else begin
      busReady <= busReq;
      busErr   <= cmd.err;
      busRdata <= rdNext;
    end
  end

endmodule

// File: rtl/chan_ctrl_hub.sv
module chan_ctrl_hub
  import hub_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busReq,
  input  logic                   busWe,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  output logic                   busReady,
  output logic                   busErr,
  output logic [N_CH-1:0]        chReq,
  output logic                   chWe,
  output logic [5:0]             chAddr,
  output logic [DATA_W-1:0]      chWdata,
  input  logic [N_CH*DATA_W-1:0] chRdata,
  output logic [N_CH-1:0]        clkGateEn,
  output logic [N_CH-1:0]        startStb,
  output logic [N_CH-1:0]        stopStb
);

  localparam int IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;

  hubCmd_t          cmd;
  logic [IDX_W-1:0] chIdx;
  logic [1:0]       unusedAddrLsb;

  assign unusedAddrLsb = busAddr[1:0];
  assign chWe          = busWe;
  assign chAddr        = busAddr[WIN_SHIFT-1:2];
  assign chWdata       = busWdata;

  hub_ctrl #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .busReq   (busReq),
    .busWe    (busWe),
    .busAddrW (busAddr[ADDR_W-1:2]),
    .cmd      (cmd),
    .chOneHot (chReq),
    .chIdx    (chIdx)
  );

  hub_dp #(.N_CH(N_CH), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busReq   (busReq),
    .busWdata (busWdata),
    .cmd      (cmd),
    .chIdx    (chIdx),
    .chRdata  (chRdata),
    .clkEn    (clkGateEn),
    .startStb (startStb),
    .stopStb  (stopStb),
    .busRdata (busRdata),
    .busReady (busReady),
    .busErr   (busErr)
  );

endmodule

// File: rtl/hub_chk.sv
module hub_chk #(
  parameter int N_CH = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWe,
  input logic [DATA_W-1:0] busRdata,
  input logic              busReady,
  input logic              busErr,
  input logic [N_CH-1:0]   chReq,
  input logic [N_CH-1:0]   clkGateEn,
  input logic [N_CH-1:0]   startStb,
  input logic [N_CH-1:0]   stopStb
);

  initial begin
    AST_CHAN_LIMIT: assert (N_CH >= 1 && N_CH <= 16 && DATA_W >= 32); // R7
  end

  AST_REPLY_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    busReq |=> busReady); // R2
  AST_NO_SPURIOUS_REPLY: assert property (@(posedge clk) disable iff (!rstN)
    !busReq |=> !busReady); // R2
  AST_CHSEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chReq)); // R1
  AST_CHSEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (chReq != '0) |-> busReq); // R1
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> (busReady && busRdata == '0)); // R8
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (startStb & ~clkGateEn) == '0); // R6
  AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (startStb & stopStb) == '0); // R7
  AST_STROBE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (startStb != '0 || stopStb != '0) |-> $past(busReq && busWe)); // R5

endmodule

bind chan_ctrl_hub hub_chk #(.N_CH(N_CH), .DATA_W(DATA_W)) u_hub_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busReq    (busReq),
  .busWe     (busWe),
  .busRdata  (busRdata),
  .busReady  (busReady),
  .busErr    (busErr),
  .chReq     (chReq),
  .clkGateEn (clkGateEn),
  .startStb  (startStb),
  .stopStb   (stopStb)
);

// File: tb/chan_ctrl_hub_test.sv
module chan_ctrl_hub_test;

  localparam int N = 4;
  localparam int DW = 32;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busReq = 1'b0;
  logic          busWe = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic          busReady;
  logic          busErr;
  logic [N-1:0]  chReq;
  logic          chWe;
  logic [5:0]    chAddr;
  logic [DW-1:0] chWdata;
  logic [N*DW-1:0] chRdata;
  logic [N-1:0]  clkGateEn;
  logic [N-1:0]  startStb;
  logic [N-1:0]  stopStb;

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  // channel models: {0xA0+k, zeros, word index}
  always_comb begin
    for (int k = 0; k < N; k++)
      chRdata[k*DW +: DW] = {8'hA0 + 8'(k), 18'h0, chAddr};
  end

  chan_ctrl_hub #(.N_CH(N), .DATA_W(DW), .ADDR_W(AW)) uut (.*);

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [31:0]   wd;
    logic [31:0]   rd;
    logic          err;
    logic [3:0]    ce;
    logic [3:0]    st;
    logic [3:0]    sp;
    logic [3:0]    cr;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 13'h000, 32'h5,         32'h0,        1'b0, 4'h5, 4'h0, 4'h0, 4'h0}, // R4 write
    '{1'b0, 13'h000, 32'h0,         32'h5,        1'b0, 4'h5, 4'h0, 4'h0, 4'h0}, // R4 read
    '{1'b1, 13'h004, 32'hF,         32'h0,        1'b0, 4'h5, 4'h5, 4'h0, 4'h0}, // R6 masked start
    '{1'b0, 13'h004, 32'h0,         32'h0,        1'b0, 4'h5, 4'h0, 4'h0, 4'h0}, // R5 reads zero
    '{1'b1, 13'h008, 32'hA,         32'h0,        1'b0, 4'h5, 4'h0, 4'hA, 4'h0}, // R5 stop
    '{1'b1, 13'h00C, 32'h0001_0005, 32'h0,        1'b0, 4'h5, 4'h4, 4'h1, 4'h0}, // R7 stop wins ch0
    '{1'b1, 13'h000, 32'hF,         32'h0,        1'b0, 4'hF, 4'h0, 4'h0, 4'h0}, // R4
    '{1'b1, 13'h00C, 32'h0000_000F, 32'h0,        1'b0, 4'hF, 4'hF, 4'h0, 4'h0}, // R7 start all
    '{1'b1, 13'h00C, 32'h000F_000F, 32'h0,        1'b0, 4'hF, 4'h0, 4'hF, 4'h0}, // R7 all collide
    '{1'b0, 13'h108, 32'h0,         32'hA000_0002,1'b0, 4'hF, 4'h0, 4'h0, 4'h1}, // R3 ch0 word2
    '{1'b0, 13'h4FC, 32'h0,         32'hA300_003F,1'b0, 4'hF, 4'h0, 4'h0, 4'h8}, // R1 ch3 last word
    '{1'b1, 13'h204, 32'h1234,      32'h0,        1'b0, 4'hF, 4'h0, 4'h0, 4'h2}, // R1 ch1 write
    '{1'b0, 13'h500, 32'h0,         32'h0,        1'b1, 4'hF, 4'h0, 4'h0, 4'h0}, // R8 no ch4
    '{1'b1, 13'h010, 32'hFFFF,      32'h0,        1'b1, 4'hF, 4'h0, 4'h0, 4'h0}, // R8 shared hole
    '{1'b1, 13'h1FFC,32'h0,         32'h0,        1'b1, 4'hF, 4'h0, 4'h0, 4'h0}, // R8 top region
    '{1'b0, 13'h003, 32'h0,         32'hF,        1'b0, 4'hF, 4'h0, 4'h0, 4'h0}, // R8 lsb ignored
    '{1'b1, 13'h000, 32'h0,         32'h0,        1'b0, 4'h0, 4'h0, 4'h0, 4'h0}, // R4 gate all
    '{1'b1, 13'h004, 32'hF,         32'h0,        1'b0, 4'h0, 4'h0, 4'h0, 4'h0}  // R6 none enabled
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(busReady == 0 && busErr == 0 && busRdata == 0, "R9 bus", {busReady, busErr, busRdata[29:0]}, 0);
    chk(clkGateEn == 0 && startStb == 0 && stopStb == 0, "R9 chan", {clkGateEn, startStb, stopStb}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busReady == 0, "R2 idle", busReady, 0);

    for (int i = 0; i < NV; i++) begin
      busReq = 1'b1;
      busWe = VEC[i].we;
      busAddr = VEC[i].addr;
      busWdata = VEC[i].wd;
      #5;
      chk(chReq == VEC[i].cr, "R1 chReq", chReq, VEC[i].cr);
      @(negedge clk);
      chk(busReady == 1, "R2 ready", busReady, 1);
      chk(busRdata == VEC[i].rd, "R3 rdata", busRdata, VEC[i].rd);
      chk(busErr == VEC[i].err, "R8 err", busErr, VEC[i].err);
      chk(clkGateEn == VEC[i].ce, "R4 clkGateEn", clkGateEn, VEC[i].ce);
      chk(startStb == VEC[i].st, "R6 startStb", startStb, VEC[i].st);
      chk(stopStb == VEC[i].sp, "R5 stopStb", stopStb, VEC[i].sp);
    end

    // R5 strobes last one cycle; R2 no reply without request
    busReq = 1'b0;
    @(negedge clk);
    chk(busReady == 0, "R2 drop", busReady, 0);
    chk(startStb == 0 && stopStb == 0, "R5 one cycle", {startStb, stopStb}, 0);

    // R1 forwarded fields on a channel write
    busReq = 1'b1; busWe = 1'b1; busAddr = 13'h3A8; busWdata = 32'hDEAD_BEEF;
    #5;
    chk(chReq == 4'h4 && chWe == 1 && chAddr == 6'h2A && chWdata == 32'hDEAD_BEEF,
        "R1 forward", {chReq, chWe, chAddr}, {4'h4, 1'b1, 6'h2A});
    @(negedge clk);
    chk(busRdata == 0, "R3 write zero", busRdata, 0);

    // R7 mixed: enable 0,1; start 0,1,2; stop 1,3
    busWe = 1'b1; busAddr = 13'h000; busWdata = 32'h3;
    @(negedge clk);
    busAddr = 13'h00C; busWdata = 32'h000A_0007;
    @(negedge clk);
    chk(startStb == 4'h1, "R7 start", startStb, 4'h1);
    chk(stopStb == 4'hA, "R7 stop", stopStb, 4'hA);

    // R8 unmapped write leaves enable untouched
    busAddr = 13'h0FC; busWdata = 32'hF;
    @(negedge clk);
    chk(clkGateEn == 4'h3 && busErr, "R8 ignored", clkGateEn, 4'h3);

    // R9 reset clears enables
    busReq = 1'b0;
    rstN = 1'b0;
    #5;
    chk(clkGateEn == 0 && busReady == 0, "R9 rereset", clkGateEn, 0);
    done = 1;
    finishRun();
  end

endmodule